// File: doc/BRIEF.md
# Transmit FIFO with Adaptive Start Gate

This block buffers outgoing data words between a host write port and a card data-line serializer. It also decides when a block write toward the card may begin. The host pushes words one at a time. The serializer pops them in write order. A one-cycle start pulse tells the serializer that enough data is buffered for the transfer to proceed without starving.

The start point depends on a small policy that is latched at each new command.

- **Eager mode:** the transfer begins as soon as any word is present.
- **Threshold mode:** the fill level that triggers the start is chosen from how the block length compares with the FIFO depth. Long blocks wait for half the FIFO. Medium blocks wait for a quarter. Short blocks wait until the whole block is buffered.

Sticky overflow and underflow flags report misuse of the write and pop ports. Depending on a policy bit, these flags are cleared either by a status read or by the next command.

Top module: `wfifo_adaptive_start`

## Requirements
- R1: After reset the level is 0, both flags are 0, and `pop_valid` and `xfer_start` are 0. No start pulse is produced until the first `cmd_strobe`, even when words are buffered.
- R2: When the latched eager bit is 1, `xfer_start` pulses in the cycle after the level first becomes at least 1.
- R3: When the latched eager bit is 0 and 4×length ≥ 3×DEPTH, `xfer_start` pulses in the cycle after the level first reaches DEPTH/2 (8 for DEPTH=16).
- R4: When the latched eager bit is 0, 4×length < 3×DEPTH and 2×length ≥ DEPTH, `xfer_start` pulses in the cycle after the level first reaches DEPTH/4 (4 for DEPTH=16).
- R5: When the latched eager bit is 0 and 2×length < DEPTH, `xfer_start` pulses in the cycle after the level first reaches the block length.
- R6: At most one start pulse is produced per block. The gate re-arms once the serializer has popped the latched block length in words, after which a new pulse may follow as soon as the threshold holds again.
- R7: A write while the level equals DEPTH is dropped. It leaves the level at DEPTH and sets `ovf_flag`.
- R8: A pop request while the FIFO is empty, after a start pulse in the current block, sets `unf_flag` and produces no `pop_valid`. The same request before any start in the block leaves `unf_flag` at 0.
- R9: With the latched clear policy at 1, a `stat_rd` cycle clears a set flag, unless a new error event occurs in the same cycle.
- R10: With the latched clear policy at 0, `stat_rd` leaves a set flag unchanged, and `cmd_strobe` clears it. The policy in force before that command decides whether the clear happens.
- R11: Block length, eager bit and clear policy are sampled only on `cmd_strobe`. Changing those inputs between strobes has no effect on the start point.
- R12: Each accepted pop presents the oldest word on `pop_data` with `pop_valid` high in the next cycle, in the order the words were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host word write strobe |
| wr_data | input | DW | Host write word |
| cmd_strobe | input | 1 | New transfer command; latches the configuration inputs |
| cfg_blk_len | input | LEN_W | Block length in words |
| cfg_immediate | input | 1 | 1: start on the first buffered word; 0: adaptive threshold |
| cfg_clr_on_read | input | 1 | 1: status read clears flags; 0: next command clears flags |
| stat_rd | input | 1 | Status read strobe |
| pop_req | input | 1 | Serializer pop request |
| pop_data | output | DW | Popped word, registered |
| pop_valid | output | 1 | `pop_data` holds a word this cycle |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| level | output | $clog2(DEPTH)+1 | Current number of buffered words |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |

## Verification
A wrong threshold selection appears as a start pulse at the wrong fill level. It is visible one cycle after the write that should, or should not, have crossed the threshold. A popped-word counter that is off shows up as a missing or duplicated start pulse in the cycle after the block's last pop. Pointer or count corruption surfaces at the next pop as out-of-order data, or as a level that does not return to zero. A flag that fails to set or clear is visible on the port in the cycle after the write, pop, status read or command that should have changed it.

// File: rtl/wfas_pkg.sv
package wfas_pkg;

  typedef enum logic [1:0] {
    START_ANY,
    START_HALF,
    START_QUARTER,
    START_WHOLE
  } start_rule_e;

  // Pick the start rule from the eager bit and the block/FIFO size ratio.
  function automatic start_rule_e pick_rule(input logic eager,
                                            input int unsigned len,
                                            input int unsigned depth);
    if (eager)                      return START_ANY;
    else if (len * 4 >= depth * 3)  return START_HALF;
    else if (len * 2 >= depth)      return START_QUARTER;
    else                            return START_WHOLE;
  endfunction

endpackage

// File: rtl/wfas_store.sv
module wfas_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic          pop_valid_o,
  output logic          pop_ok_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] count_q;
  logic          push_ok, pop_ok;

  assign full_o   = (count_q == CW'(DEPTH));
  assign empty_o  = (count_q == '0);
  assign push_ok  = push_i && !full_o;
  assign pop_ok   = pop_i && !empty_o;
  assign pop_ok_o = pop_ok;
  assign count_o  = count_q;

  // Storage write port, no reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= push_data_i;
  end

  // Registered read port.
  always_ff @(posedge clk) begin
    if (pop_ok) pop_data_o <= mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q        <= '0;
      rp_q        <= '0;
      count_q     <= '0;
      pop_valid_o <= 1'b0;
    end else begin
      pop_valid_o <= pop_ok;
      if (push_ok) wp_q <= wp_q + 1'b1;
      if (pop_ok)  rp_q <= rp_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R7: a rejected write must not change the occupancy.
  a_r7_drop_keeps_level: assert property (@(posedge clk) disable iff (rst)
    (push_i && full_o && !pop_i) |=> (count_q == CW'(DEPTH)));

  // R12: occupancy never exceeds the depth.
  a_r12_level_bound: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));

  // R8: a pop on an empty FIFO yields no data.
  a_r8_no_data_when_empty: assert property (@(posedge clk) disable iff (rst)
    (pop_i && empty_o) |=> !pop_valid_o);

endmodule

// File: rtl/wfas_gate.sv
module wfas_gate
  import wfas_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = 10,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             eager_i,
  input  logic [CW-1:0]    count_i,
  input  logic             pop_ok_i,
  output logic             start_o,
  output logic             started_o
);

  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] popped_q;
  logic             eager_q;
  logic             armed_q;
  logic             started_q;
  start_rule_e      rule;
  logic [31:0]      thr;
  logic             meets;
  logic             block_done;

  always_comb begin
    rule = pick_rule(eager_q, 32'(len_q), DEPTH);
    case (rule)
      START_ANY:     thr = 32'd1;
      START_HALF:    thr = 32'(DEPTH / 2);
      START_QUARTER: thr = 32'(DEPTH / 4);
      default:       thr = 32'(len_q);
    endcase
  end

  assign meets      = (32'(count_i) >= thr);
  assign block_done = pop_ok_i && armed_q && (popped_q == len_q - 1'b1);
  assign started_o  = started_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q     <= '0;
      eager_q   <= 1'b0;
      armed_q   <= 1'b0;
      started_q <= 1'b0;
      popped_q  <= '0;
      start_o   <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (cmd_i) begin
        len_q     <= len_i;
        eager_q   <= eager_i;
        armed_q   <= 1'b1;
        started_q <= 1'b0;
        popped_q  <= '0;
      end else begin
        if (armed_q && !started_q && meets) begin
          start_o   <= 1'b1;
          started_q <= 1'b1;
        end
        if (pop_ok_i && armed_q) begin
          if (block_done) begin
            popped_q  <= '0;
            started_q <= 1'b0;
          end else begin
            popped_q <= popped_q + 1'b1;
          end
        end
      end
    end
  end

  // R6: the start indication is a single-cycle pulse.
  a_r6_pulse_once: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  // R11: a command never produces a start in the following cycle.
  a_r11_no_start_after_cmd: assert property (@(posedge clk) disable iff (rst)
    cmd_i |=> !start_o);

  // R1: nothing starts before the first command.
  a_r1_idle_until_cmd: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> !start_o);

endmodule

// File: rtl/wfas_err.sv
module wfas_err #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_i,
  input  logic             clr_pol_i,
  input  logic             stat_rd_i,
  input  logic [NFLAG-1:0] evt_i,
  output logic [NFLAG-1:0] flag_o
);

  logic pol_q;
  logic clr;

  // Clearing follows the policy in force before any new command.
  assign clr = pol_q ? stat_rd_i : cmd_i;

  always_ff @(posedge clk) begin
    if (rst)        pol_q <= 1'b0;
    else if (cmd_i) pol_q <= clr_pol_i;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flag_o[g] <= 1'b0;
      else if (evt_i[g]) flag_o[g] <= 1'b1;
      else if (clr)      flag_o[g] <= 1'b0;
    end

    // R7, R8: an error event always leaves the flag set.
    a_r7_sticky_set: assert property (@(posedge clk) disable iff (rst)
      evt_i[g] |=> flag_o[g]);

    // R10: under command-clear policy a status read never clears.
    a_r10_hold_on_read: assert property (@(posedge clk) disable iff (rst)
      (flag_o[g] && !pol_q && !cmd_i) |=> flag_o[g]);

    // R9: under read-clear policy a status read clears.
    a_r9_clear_on_read: assert property (@(posedge clk) disable iff (rst)
      (flag_o[g] && pol_q && stat_rd_i && !evt_i[g]) |=> !flag_o[g]);
  end

endmodule

// File: rtl/wfifo_adaptive_start.sv
module wfifo_adaptive_start #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int LEN_W = 10,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             cmd_strobe,
  input  logic [LEN_W-1:0] cfg_blk_len,
  input  logic             cfg_immediate,
  input  logic             cfg_clr_on_read,
  input  logic             stat_rd,
  input  logic             pop_req,
  output logic [DW-1:0]    pop_data,
  output logic             pop_valid,
  output logic             xfer_start,
  output logic [CW-1:0]    level,
  output logic             ovf_flag,
  output logic             unf_flag
);

  logic       pop_ok;
  logic       full;
  logic       empty;
  logic       started;
  logic [1:0] evt;
  logic [1:0] flags;

  wfas_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk         (clk),
    .rst         (rst),
    .push_i      (wr_en),
    .push_data_i (wr_data),
    .pop_i       (pop_req),
    .pop_data_o  (pop_data),
    .pop_valid_o (pop_valid),
    .pop_ok_o    (pop_ok),
    .count_o     (level),
    .full_o      (full),
    .empty_o     (empty)
  );

  wfas_gate #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .cmd_i     (cmd_strobe),
    .len_i     (cfg_blk_len),
    .eager_i   (cfg_immediate),
    .count_i   (level),
    .pop_ok_i  (pop_ok),
    .start_o   (xfer_start),
    .started_o (started)
  );

  assign evt[0] = wr_en && full;
  assign evt[1] = pop_req && empty && started;

  wfas_err #(.NFLAG(2)) u_err (
    .clk       (clk),
    .rst       (rst),
    .cmd_i     (cmd_strobe),
    .clr_pol_i (cfg_clr_on_read),
    .stat_rd_i (stat_rd),
    .evt_i     (evt),
    .flag_o    (flags)
  );

  assign ovf_flag = flags[0];
  assign unf_flag = flags[1];

endmodule

// File: tb/sim_wfifo_adaptive_start.sv
`timescale 1ns/1ps
module sim_wfifo_adaptive_start;

  localparam int DW    = 32;
  localparam int DEPTH = 16;
  localparam int LEN_W = 10;
  localparam int CW    = $clog2(DEPTH) + 1;
  localparam int NVEC  = 8;

  // {eager, block length, expected start level}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b1, 10'd5,  10'd1},
    {1'b0, 10'd16, 10'd8},
    {1'b0, 10'd12, 10'd8},
    {1'b0, 10'd11, 10'd4},
    {1'b0, 10'd8,  10'd4},
    {1'b0, 10'd7,  10'd7},
    {1'b0, 10'd3,  10'd3},
    {1'b0, 10'd1,  10'd1}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [DW-1:0]    wr_data = '0;
  logic             cmd_strobe = 1'b0;
  logic [LEN_W-1:0] cfg_blk_len = '0;
  logic             cfg_immediate = 1'b0;
  logic             cfg_clr_on_read = 1'b0;
  logic             stat_rd = 1'b0;
  logic             pop_req = 1'b0;
  logic [DW-1:0]    pop_data;
  logic             pop_valid;
  logic             xfer_start;
  logic [CW-1:0]    level;
  logic             ovf_flag;
  logic             unf_flag;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  int start_lvl = 0;

  always #2 clk = ~clk;

  wfifo_adaptive_start #(.DW(DW), .DEPTH(DEPTH), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_strobe(cmd_strobe), .cfg_blk_len(cfg_blk_len),
    .cfg_immediate(cfg_immediate), .cfg_clr_on_read(cfg_clr_on_read),
    .stat_rd(stat_rd), .pop_req(pop_req), .pop_data(pop_data),
    .pop_valid(pop_valid), .xfer_start(xfer_start), .level(level),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  always @(negedge clk) begin
    if (!rst && xfer_start) begin
      starts    <= starts + 1;
      start_lvl <= int'(level);
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic command(input logic eager, input int len, input logic clr);
    @(negedge clk);
    cfg_immediate   = eager;
    cfg_blk_len     = LEN_W'(len);
    cfg_clr_on_read = clr;
    cmd_strobe      = 1'b1;
    @(negedge clk);
    cmd_strobe      = 1'b0;
  endtask

  // One write, followed by an idle cycle so a start pulse sees this level.
  task automatic put(input logic [DW-1:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    @(negedge clk);
  endtask

  task automatic take(input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
    chk(pop_valid === 1'b1 && pop_data === exp, req, pop_data, exp);
  endtask

  task automatic read_status();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int s0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    chk(level == 0, "R1 level", level, 0);
    chk(ovf_flag == 0 && unf_flag == 0, "R1 flags", {ovf_flag, unf_flag}, 0);
    chk(pop_valid == 0 && xfer_start == 0, "R1 outputs", {pop_valid, xfer_start}, 0);

    // R1: no start before the first command; R8: no underflow before a start
    put(32'h5555_0001);
    idle(2);
    chk(starts == 0, "R1 no start before command", starts, 0);
    take(32'h5555_0001, "R12 pre-command data");
    @(negedge clk); pop_req = 1'b1;
    @(negedge clk); pop_req = 1'b0;
    chk(pop_valid == 0, "R8 no data on empty", pop_valid, 0);
    idle(1);
    chk(unf_flag == 0, "R8 no underflow before start", unf_flag, 0);

    // Threshold table: R2, R3, R4, R5
    for (int v = 0; v < NVEC; v++) begin
      logic eager;
      int len, thr;
      string tag;
      eager = VEC[v][20];
      len   = int'(VEC[v][19:10]);
      thr   = int'(VEC[v][9:0]);
      if (eager)                 tag = "R2";
      else if (len * 4 >= 3 * DEPTH) tag = "R3";
      else if (len * 2 >= DEPTH) tag = "R4";
      else                       tag = "R5";
      command(eager, len, 1'b0);
      s0 = starts;
      for (int i = 0; i < len; i++) put(32'hA000_0000 + v * 256 + i);
      idle(2);
      chk(starts - s0 == 1, {tag, " one start"}, starts - s0, 1);
      chk(start_lvl == thr, {tag, " start level"}, start_lvl, thr);
      for (int i = 0; i < len; i++) take(32'hA000_0000 + v * 256 + i, "R12 order");
      idle(2);
      chk(level == 0, "R12 drained", level, 0);
      chk(starts - s0 == 1, "R6 no start after empty block", starts - s0, 1);
    end

    // R6: one pulse per block, re-armed after length pops
    command(1'b1, 2, 1'b0);
    s0 = starts;
    put(32'hB0);
    put(32'hB1);
    put(32'hB2);
    idle(2);
    chk(starts - s0 == 1, "R6 single pulse", starts - s0, 1);
    take(32'hB0, "R12 rearm data");
    take(32'hB1, "R12 rearm data");
    idle(2);
    chk(starts - s0 == 2, "R6 rearm pulse", starts - s0, 2);

    // R8: underflow after a start
    take(32'hB2, "R12 last word");
    @(negedge clk); pop_req = 1'b1;
    @(negedge clk); pop_req = 1'b0;
    chk(pop_valid == 0, "R8 no data on underflow", pop_valid, 0);
    idle(1);
    chk(unf_flag == 1, "R8 underflow set", unf_flag, 1);

    // R10: read does not clear under command policy; command does
    read_status();
    idle(1);
    chk(unf_flag == 1, "R10 read keeps flag", unf_flag, 1);
    command(1'b1, 4, 1'b1);
    idle(1);
    chk(unf_flag == 0, "R10 command clears flag", unf_flag, 0);

    // R7: overflow
    for (int i = 0; i < DEPTH + 1; i++) put(32'hC000 + i);
    idle(1);
    chk(level == DEPTH, "R7 level stays full", level, DEPTH);
    chk(ovf_flag == 1, "R7 overflow set", ovf_flag, 1);

    // R9: read clears under read policy
    read_status();
    idle(1);
    chk(ovf_flag == 0, "R9 read clears flag", ovf_flag, 0);
    for (int i = 0; i < DEPTH; i++) take(32'hC000 + i, "R7 dropped word not stored");
    idle(2);
    chk(level == 0, "R7 drained", level, 0);

    // R11: live configuration changes are ignored between commands
    command(1'b0, 16, 1'b1);
    @(negedge clk);
    cfg_immediate = 1'b1;
    cfg_blk_len   = LEN_W'(1);
    s0 = starts;
    for (int i = 0; i < 7; i++) put(32'hD000 + i);
    idle(2);
    chk(starts - s0 == 0, "R11 no early start", starts - s0, 0);
    put(32'hD007);
    idle(2);
    chk(starts - s0 == 1 && start_lvl == 8, "R11 latched threshold", start_lvl, 8);

    finish_run();
  end

endmodule